// File: doc/BRIEF.md
# I2C Register Slave with Run-Time Self-Addressing

This block is an I2C target that gives a host access to a byte-wide register file. It runs entirely on an oversampled system clock. Both bus lines pass through a short synchronizer chain, and every protocol event is recovered from the sampled levels. A write transfer begins with a command byte that loads an 8-bit register pointer. Every data byte after it produces a one-cycle write strobe, which carries the pointer and the byte, and the pointer then advances. A read transfer returns bytes starting at the pointer and keeps going until the host answers a byte with a not-acknowledge.

After reset the device address is all zeros. A write to register 0x2D reprograms the two low address bits from two hard-wired key-node levels. In a multi-drop system, every device still on the zero address answers the same broadcast write, and each one picks up its own wiring. The key levels are taken exactly as they are sampled when the data byte completes. They are not filtered.

Top module: `i2c_selfaddr_slave`

## Requirements
- R1: While reset is held and immediately after it, `sda_oe` is 0 and neither `reg_wr` nor `reg_rd` is asserted.
- R2: After reset the slave acknowledges only the 7-bit address 0000000. Any other address is answered with SDA released (NACK).
- R3: Writing a byte whose bit 0 is 1 to register 0x2D sets the device address to 00000 followed by `key_lvl[1]` and `key_lvl[0]`, where a level of 1 means a shorted node. Writing a byte whose bit 0 is 0 to 0x2D restores the address 0000000.
- R4: The key levels used are the ones present when that data byte completes. A later change of `key_lvl` has no effect on the address.
- R5: In a write transfer, the first byte after the address (R/W bit = 0) loads the pointer. Each later byte gives exactly one `reg_wr` pulse with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte, and the pointer then increments.
- R6: The pointer is 8 bits wide and wraps from 0xFF to 0x00, both for writes and for reads.
- R7: In a read transfer (R/W bit = 1), the bytes at the pointer are shifted out MSB first and the pointer increments after each one. After the master NACKs, the slave keeps SDA released.
- R8: The slave pulls SDA low during the ninth clock after a matching address and after every byte it receives.
- R9: After a non-matching address, the slave drives SDA for no later bit and gives no strobe until the next START or STOP.
- R10: A repeated START restarts address decoding at any point in a transfer. A STOP returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock level as seen at the pad |
| sda_in | input | 1 | Bus data level as seen at the pad |
| key_lvl | input | 2 | Key-node levels for address bits 1:0 (1 = shorted) |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_addr | output | 8 | Register pointer (write or read address) |
| reg_wdata | output | 8 | Data for `reg_wr` |
| reg_rd | output | 1 | One-cycle strobe when a read byte is fetched from `reg_addr` |
| reg_rdata | input | 8 | Register contents at `reg_addr`, combinational |

## Verification
The host model drives several kinds of traffic:
- multi-byte writes, where a scoreboard of expected address/data strobes separates pointer loading from pointer advance;
- reads that cross written and unwritten registers;
- writes and reads that straddle 0xFF, which separate correct wrapping from saturation.

Address probes are run before and after each self-address command, and the key levels are changed right after the command. These show whether the address bits were loaded from the keys, held afterwards, or cleared. Repeated STARTs into a foreign address and back, together with reads from an unmatched address, check that the slave ignores bytes not meant for it and resynchronises.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int DEV_W   = 7;
    localparam int BYTE_W  = 8;
    localparam int BITS_W  = $clog2(BYTE_W + 1);
    localparam int LO_W    = 2;

    localparam logic [BYTE_W-1:0] SELF_ADDR_REG = 8'h2D;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_WDATA,
        PH_RDATA,
        PH_IGNORE
    } phase_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    function automatic logic [DEV_W-1:0] dev_from_lo(input logic [LO_W-1:0] lo);
        return {{(DEV_W-LO_W){1'b0}}, lo};
    endfunction

endpackage

// File: rtl/i2cs_linemon.sv
module i2cs_linemon
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_d, sda_d;
    logic scl_s, sda_s;

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_in;
                    sda_sh <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
                    sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
        ev.sda      = sda_s;
    end

endmodule

// File: rtl/i2cs_selfaddr.sv
module i2cs_selfaddr
    import i2cs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             use_keys,
    input  logic [LO_W-1:0]  key_lvl,
    output logic [DEV_W-1:0] dev
);
    logic [LO_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst)       lo_q <= '0;
        else if (load) lo_q <= use_keys ? key_lvl : '0;
    end

    assign dev = dev_from_lo(lo_q);

    // the address only moves on a self-address write
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(dev));

    // a write with bit 0 set takes the keys seen in that cycle
    assert_addr_from_keys_R3: assert property (@(posedge clk) disable iff (rst)
        (load && use_keys) |=> (dev == dev_from_lo($past(key_lvl))));

endmodule

// File: rtl/i2c_selfaddr_slave.sv
module i2c_selfaddr_slave
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [1:0] key_lvl,
    output logic       sda_oe,
    output logic       reg_wr,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_rd,
    input  logic [7:0] reg_rdata
);
    line_ev_t ev;
    phase_t   phase;
    logic              in_ack, rw, mnack, oe_q;
    logic [BITS_W-1:0] bitcnt;
    logic [BYTE_W-1:0] shreg, ptr, byte_in;
    logic [DEV_W-1:0]  dev;
    logic              receiving, last_rise, self_load;

    i2cs_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    assign byte_in   = {shreg[BYTE_W-2:0], ev.sda};
    assign receiving = (phase == PH_ADDR) || (phase == PH_CMD) || (phase == PH_WDATA);
    assign last_rise = ev.scl_rise && !in_ack && receiving && (bitcnt == BITS_W'(BYTE_W-1));

    assign reg_wr    = last_rise && (phase == PH_WDATA);
    assign reg_wdata = byte_in;
    assign reg_addr  = ptr;
    assign reg_rd    = ev.scl_fall && in_ack &&
                       (((phase == PH_ADDR) && rw) || ((phase == PH_RDATA) && !mnack));
    assign self_load = reg_wr && (ptr == SELF_ADDR_REG);
    assign sda_oe    = oe_q;

    i2cs_selfaddr u_addr (
        .clk(clk), .rst(rst), .load(self_load), .use_keys(byte_in[0]),
        .key_lvl(key_lvl), .dev(dev)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            in_ack <= 1'b0;
            rw     <= 1'b0;
            mnack  <= 1'b0;
            oe_q   <= 1'b0;
            bitcnt <= '0;
            shreg  <= '0;
            ptr    <= '0;
        end else if (ev.start) begin
            phase  <= PH_ADDR;
            in_ack <= 1'b0;
            bitcnt <= '0;
            oe_q   <= 1'b0;
        end else if (ev.stop) begin
            phase  <= PH_IDLE;
            in_ack <= 1'b0;
            bitcnt <= '0;
            oe_q   <= 1'b0;
        end else if (ev.scl_rise) begin
            if (in_ack) begin
                if (phase == PH_RDATA) mnack <= ev.sda;
            end else if (receiving) begin
                shreg  <= byte_in;
                bitcnt <= bitcnt + 1'b1;
                if (last_rise) begin
                    unique case (phase)
                        PH_ADDR:  if (byte_in[BYTE_W-1:1] == dev) rw <= byte_in[0];
                                  else phase <= PH_IGNORE;
                        PH_CMD:   ptr <= byte_in;
                        default:  ptr <= ptr + 1'b1;
                    endcase
                end
            end else if (phase == PH_RDATA) begin
                bitcnt <= bitcnt + 1'b1;
            end
        end else if (ev.scl_fall) begin
            if (in_ack) begin
                in_ack <= 1'b0;
                bitcnt <= '0;
                if (reg_rd) begin
                    phase <= PH_RDATA;
                    shreg <= reg_rdata;
                    ptr   <= ptr + 1'b1;
                    oe_q  <= ~reg_rdata[BYTE_W-1];
                end else begin
                    oe_q <= 1'b0;
                    case (phase)
                        PH_ADDR, PH_CMD, PH_WDATA: phase <= PH_WDATA;
                        PH_RDATA:                  phase <= PH_IGNORE;
                        default:                   phase <= phase;
                    endcase
                    if (phase == PH_ADDR) phase <= PH_CMD;
                end
            end else if ((bitcnt == BITS_W'(BYTE_W)) && (receiving || phase == PH_RDATA)) begin
                in_ack <= 1'b1;
                oe_q   <= receiving;
            end else if ((phase == PH_RDATA) && (bitcnt != '0)) begin
                oe_q <= ~shreg[3'd7 - bitcnt[2:0]];
            end
        end
    end

    assert_idle_release_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE || phase == PH_IGNORE) |-> !sda_oe);

    assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);

    assert_wr_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_addr == $past(reg_addr) + 8'd1));

    assert_rd_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> (reg_addr == $past(reg_addr) + 8'd1));

    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    assert_ack_low_R8: assert property (@(posedge clk) disable iff (rst)
        (in_ack && receiving) |-> sda_oe);

endmodule

// File: tb/i2c_selfaddr_slave_test.sv
module i2c_selfaddr_slave_test;
    localparam int Q = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst, m_scl, m_sda;
    logic [1:0] keys;
    logic       sda_oe, reg_wr, reg_rd;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    wire        sda_line = m_sda & ~sda_oe;

    logic [7:0]  regfile [256];
    logic [7:0]  exp_mem [256];
    logic [15:0] exp_q [$];
    int checks = 0, fails = 0;
    bit done = 0;

    assign reg_rdata = regfile[reg_addr];

    i2c_selfaddr_slave uut (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line), .key_lvl(keys),
        .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // monitor: register file model plus scoreboard of write strobes
    initial begin
        for (int i = 0; i < 256; i++) regfile[i] = 8'(i) ^ 8'h5A;
        forever begin
            @(negedge clk);
            if (!rst && reg_wr) begin
                if (exp_q.size() == 0)
                    check(0, "R9", "unexpected write strobe", {reg_addr, reg_wdata}, 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check({reg_addr, reg_wdata} == e, "R5", "write strobe addr/data",
                          {reg_addr, reg_wdata}, e);
                end
                regfile[reg_addr] = reg_wdata;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1; tick(Q); m_scl = 1; tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 0; tick(Q); m_scl = 1; tick(Q); m_sda = 1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q); m_scl = 1; tick(2 * Q); m_scl = 0; tick(2);
        end
        m_sda = 1; tick(Q); m_scl = 1; tick(Q);
        ack = !sda_line;
        tick(Q); m_scl = 0; tick(2);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        m_sda = 1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); m_scl = 1; tick(Q); b[i] = sda_line; tick(Q); m_scl = 0; tick(2);
        end
        m_sda = nack; tick(Q); m_scl = 1; tick(2 * Q); m_scl = 0; tick(2); m_sda = 1;
    endtask

    // write n bytes starting at cmd; values follow a simple progression
    task automatic write_seq(input logic [6:0] dev, input logic [7:0] cmd, input int n,
                             input logic [7:0] seed, input string req);
        logic ack;
        bus_start();
        send_byte({dev, 1'b0}, ack);
        check(ack, "R8", "address ack on write", ack, 1);
        send_byte(cmd, ack);
        check(ack, "R8", "command ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] a, d;
            a = cmd + 8'(k);
            d = seed + 8'(k * 31);
            exp_q.push_back({a, d});
            exp_mem[a] = d;
            send_byte(d, ack);
            check(ack, req, "data byte ack", ack, 1);
        end
        bus_stop();
    endtask

    task automatic read_seq(input logic [6:0] dev, input logic [7:0] cmd, input int n,
                            input string req);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte({dev, 1'b0}, ack);
        send_byte(cmd, ack);
        bus_start();
        send_byte({dev, 1'b1}, ack);
        check(ack, "R8", "address ack on read", ack, 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] a;
            a = cmd + 8'(k);
            recv_byte(k == n - 1, b);
            check(b == exp_mem[a], req, "read byte", b, exp_mem[a]);
        end
        tick(Q);
        check(sda_oe == 0, "R7", "SDA released after NACK", sda_oe, 0);
        bus_stop();
        tick(4);
        check(sda_oe == 0, "R10", "SDA released after STOP", sda_oe, 0);
    endtask

    task automatic probe(input logic [6:0] dev, input bit exp_ack, input string req);
        logic ack;
        bus_start();
        send_byte({dev, 1'b0}, ack);
        check(ack == exp_ack, req, "address probe", ack, exp_ack);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "R10", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic ack;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ 8'h5A;
        rst = 1; m_scl = 1; m_sda = 1; keys = 2'b10;
        tick(2);
        check(sda_oe == 0 && reg_wr == 0 && reg_rd == 0, "R1", "outputs in reset",
              {sda_oe, reg_wr, reg_rd}, 0);
        tick(3);
        rst = 0;
        tick(2);
        check(sda_oe == 0 && reg_wr == 0 && reg_rd == 0, "R1", "outputs after reset",
              {sda_oe, reg_wr, reg_rd}, 0);

        // foreign address: NACK and bytes after it ignored
        bus_start();
        send_byte({7'h13, 1'b0}, ack);
        check(!ack, "R2", "foreign address NACK", ack, 0);
        send_byte(8'hC3, ack);
        check(!ack, "R9", "byte after foreign address ignored", ack, 0);
        bus_stop();
        probe(7'h02, 0, "R2");

        // write and read back
        write_seq(7'h00, 8'h20, 3, 8'h11, "R5");
        read_seq(7'h00, 8'h20, 4, "R7");

        // pointer wrap on write and read
        write_seq(7'h00, 8'hFE, 3, 8'hA0, "R6");
        read_seq(7'h00, 8'hFF, 2, "R6");

        // self-address from keys 2'b10, keys then change at once
        write_seq(7'h00, 8'h2D, 1, 8'h01, "R3");
        keys = 2'b01;
        probe(7'h00, 0, "R3");
        probe(7'h02, 1, "R4");
        probe(7'h01, 0, "R4");
        read_seq(7'h02, 8'h20, 2, "R7");

        // second broadcast with keys 2'b11
        keys = 2'b11;
        write_seq(7'h02, 8'h2D, 1, 8'h01, "R3");
        probe(7'h03, 1, "R3");
        probe(7'h02, 0, "R3");

        // data bit 0 clear returns to all-zero address
        write_seq(7'h03, 8'h2D, 1, 8'h00, "R3");
        probe(7'h00, 1, "R3");
        probe(7'h03, 0, "R3");

        // repeated START mid-write into foreign address, then back
        bus_start();
        send_byte({7'h00, 1'b0}, ack);
        send_byte(8'h40, ack);
        exp_q.push_back({8'h40, 8'h77}); exp_mem[8'h40] = 8'h77;
        send_byte(8'h77, ack);
        bus_start();
        send_byte({7'h11, 1'b0}, ack);
        check(!ack, "R10", "foreign address after repeated START", ack, 0);
        bus_start();
        send_byte({7'h00, 1'b0}, ack);
        check(ack, "R10", "own address after repeated START", ack, 1);
        send_byte(8'h41, ack);
        exp_q.push_back({8'h41, 8'h88}); exp_mem[8'h41] = 8'h88;
        send_byte(8'h88, ack);
        bus_stop();
        read_seq(7'h00, 8'h40, 2, "R10");

        // read from a foreign address: slave stays off the bus
        bus_start();
        send_byte({7'h05, 1'b1}, ack);
        check(!ack, "R9", "foreign read address NACK", ack, 0);
        recv_byte(1'b1, b);
        check(b == 8'hFF, "R9", "foreign read returns released bus", b, 8'hFF);
        bus_stop();

        tick(10);
        check(exp_q.size() == 0, "R5", "all expected strobes seen", exp_q.size(), 0);
        finish_run();
    end

endmodule